// File: doc/BRIEF.md
# Privileged Special-Register Access Unit

This unit serves the core's move-to and move-from special-register requests. Each request carries a direction, an address and, for writes, a data word. It also carries two privilege qualifiers: the supervisor bit and the user-register-access bit. The unit first checks privilege. It then checks the address against the implemented register set, which is different for reads and for writes. If both checks pass, the access goes ahead with the side effect that belongs to that register.

There are several kinds of write. Some registers store the value as written. The status register stores the value but always keeps its fixed-one bit set. The next-PC address stores nothing and instead asks the core to jump there, dropping any pending delay-slot state. The timer-mode address accepts only zero. A 512-entry shadow register window is stored when the address falls inside it. Any rejected access produces a one-cycle warning with a code that tells the core why. All outputs are registered and appear one clock after the request.

Top module: `spr_access_unit`

## Requirements
- R1: When both `sup_i` and `uacc_i` are low, a request is rejected: a read returns 0, a write changes nothing and causes no redirect, and the warning code is 1 (privilege). Privilege is checked before the address.
- R2: An address at or above the register count (0x800) is invalid: a read returns 0, a write has no effect, and the warning code is 2 (address).
- R3: Reads of the constant registers return their parameter values: 0x000 identity (0x00010203), 0x001 unit list (0x00000C05), 0x002 configuration (0x00000020). A read of 0x012 returns `prev_pc_i` as sampled with the request.
- R4: Writes to 0x014 (FPU control), 0x020 (exception PC), 0x040 (exception status), 0x080 (MAC low) and 0x081 (MAC high) store the value as written. All of them except 0x040 read back through `rd_data_o`. The exception status value appears on `exc_sr_o`.
- R5: A write to the status register 0x011 stores the value with bit 15 forced to 1. A later read returns that value.
- R6: A write to 0x010 stores nothing. It pulses `redir_o` for one cycle with `redir_pc_o` equal to the written value, which also tells the core to drop its pending delay-slot state. A read of 0x010 is an address fault (code 2).
- R7: A write of zero to 0x0A0 (timer mode) completes with no warning. A nonzero write there raises warning code 3 and changes nothing. A read of 0x0A0 is an address fault (code 2).
- R8: Addresses 0x400 to 0x5FF form a shadow window. Writes are stored and reads return the stored word, including at both ends of the window.
- R9: Any other address below 0x800 gives warning code 2 for both reads and writes. This includes a read of 0x040.
- R10: `rd_data_o`, `redir_o`, `warn_o` and `warn_code_o` each reflect exactly one request, one cycle after it. With no request they read 0. `warn_o` is high exactly when the code is nonzero.
- R11: After reset the status register reads 0x00008000. The stored registers FPU control, exception PC, exception status, MAC low and MAC high read 0. All outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request strobe, one cycle per access |
| wr_i | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| addr_i | input | 16 | Special-register address |
| wdata_i | input | 32 | Write data |
| sup_i | input | 1 | Core is in supervisor mode |
| uacc_i | input | 1 | User-mode register access permitted |
| prev_pc_i | input | 32 | Previous-PC value from the core |
| rd_data_o | output | 32 | Read result, one cycle after the request |
| redir_o | output | 1 | Redirect pulse; also drops pending delay slot |
| redir_pc_o | output | 32 | Redirect target |
| warn_o | output | 1 | Rejected-access pulse |
| warn_code_o | output | 2 | 1 privilege, 2 address, 3 illegal value |
| exc_sr_o | output | 32 | Stored exception status word |

## Verification
A vector table drives every register class in both directions under three privilege patterns: supervisor only, user-access only, and neither. This separates the privilege gate from the address decode and shows that privilege takes priority over a bad address. Each write is followed by a read of the same address, so a store, a forced bit, a dropped write and a non-stored redirect each leave a different read-back. Addresses at the window edges, in the unimplemented gap, at the register count, and the write-only or read-invalid locations test the decode boundaries. Directed tests cover reset contents, the idle cycles and back-to-back requests.

// File: rtl/spr_unit_pkg.sv
package spr_unit_pkg;

   typedef enum logic [3:0] {
      CL_VERSION, CL_UNITS, CL_CPUCFG, CL_STATUS, CL_PREVPC, CL_FPCSR,
      CL_EXCPC, CL_EXCSR, CL_MACLO, CL_MACHI, CL_NEXTPC, CL_TMODE,
      CL_SHADOW, CL_NONE
   } spr_class_e;

   typedef enum logic [1:0] {
      WARN_NONE  = 2'd0,
      WARN_PRIV  = 2'd1,
      WARN_ADDR  = 2'd2,
      WARN_VALUE = 2'd3
   } warn_code_e;

   localparam int unsigned ADR_VERSION = 'h000;
   localparam int unsigned ADR_UNITS   = 'h001;
   localparam int unsigned ADR_CPUCFG  = 'h002;
   localparam int unsigned ADR_NEXTPC  = 'h010;
   localparam int unsigned ADR_STATUS  = 'h011;
   localparam int unsigned ADR_PREVPC  = 'h012;
   localparam int unsigned ADR_FPCSR   = 'h014;
   localparam int unsigned ADR_EXCPC   = 'h020;
   localparam int unsigned ADR_EXCSR   = 'h040;
   localparam int unsigned ADR_MACLO   = 'h080;
   localparam int unsigned ADR_MACHI   = 'h081;
   localparam int unsigned ADR_TMODE   = 'h0A0;
   localparam int unsigned ADR_TOP_FIXED = 'h0A0;

   localparam int unsigned NUM_STORED = 5;

endpackage

// File: rtl/spr_decode.sv
module spr_decode
   import spr_unit_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned NUM_REGS     = 'h800,
   parameter int unsigned SHADOW_BASE  = 'h400,
   parameter int unsigned SHADOW_DEPTH = 512
) (
   input  logic [ADDR_W-1:0] addr_i,
   output spr_class_e        cls_o,
   output logic              in_range_o,
   output logic              rd_legal_o,
   output logic              wr_legal_o
);

   localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);
   localparam logic [ADDR_W:0] SH_LO = (ADDR_W+1)'(SHADOW_BASE);
   localparam logic [ADDR_W:0] SH_HI = (ADDR_W+1)'(SHADOW_BASE + SHADOW_DEPTH);

   logic [ADDR_W:0] a_ext;
   logic            in_window;

   assign a_ext      = {1'b0, addr_i};
   assign in_range_o = a_ext < LIMIT;
   assign in_window  = (SHADOW_DEPTH > 0) && (a_ext >= SH_LO) && (a_ext < SH_HI);

   always_comb begin
      unique case (addr_i)
         ADDR_W'(ADR_VERSION): cls_o = CL_VERSION;
         ADDR_W'(ADR_UNITS):   cls_o = CL_UNITS;
         ADDR_W'(ADR_CPUCFG):  cls_o = CL_CPUCFG;
         ADDR_W'(ADR_NEXTPC):  cls_o = CL_NEXTPC;
         ADDR_W'(ADR_STATUS):  cls_o = CL_STATUS;
         ADDR_W'(ADR_PREVPC):  cls_o = CL_PREVPC;
         ADDR_W'(ADR_FPCSR):   cls_o = CL_FPCSR;
         ADDR_W'(ADR_EXCPC):   cls_o = CL_EXCPC;
         ADDR_W'(ADR_EXCSR):   cls_o = CL_EXCSR;
         ADDR_W'(ADR_MACLO):   cls_o = CL_MACLO;
         ADDR_W'(ADR_MACHI):   cls_o = CL_MACHI;
         ADDR_W'(ADR_TMODE):   cls_o = CL_TMODE;
         default:              cls_o = in_window ? CL_SHADOW : CL_NONE;
      endcase
   end

   // Read and write sets differ: exception status is write-only,
   // next-PC and timer mode are write-only, constants are read-only.
   always_comb begin
      rd_legal_o = 1'b0;
      wr_legal_o = 1'b0;
      case (cls_o)
         CL_VERSION, CL_UNITS, CL_CPUCFG, CL_PREVPC:
            rd_legal_o = 1'b1;
         CL_STATUS, CL_FPCSR, CL_EXCPC, CL_MACLO, CL_MACHI, CL_SHADOW: begin
            rd_legal_o = 1'b1;
            wr_legal_o = 1'b1;
         end
         CL_EXCSR, CL_NEXTPC, CL_TMODE:
            wr_legal_o = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/spr_named_regs.sv
module spr_named_regs
   import spr_unit_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned FO_BIT = 15
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  spr_class_e        cls_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] status_o,
   output logic [DATA_W-1:0] fpcsr_o,
   output logic [DATA_W-1:0] excpc_o,
   output logic [DATA_W-1:0] excsr_o,
   output logic [DATA_W-1:0] maclo_o,
   output logic [DATA_W-1:0] machi_o
);

   localparam logic [DATA_W-1:0] FO_MASK = DATA_W'(1) << FO_BIT;
   localparam spr_class_e STORE_CLS [NUM_STORED] =
      '{CL_FPCSR, CL_EXCPC, CL_EXCSR, CL_MACLO, CL_MACHI};

   logic [DATA_W-1:0] store_q [NUM_STORED];
   logic [DATA_W-1:0] status_q;

   for (genvar i = 0; i < NUM_STORED; i++) begin : g_store
      always_ff @(posedge clk_i) begin
         if (!rst_ni)
            store_q[i] <= '0;
         else if (we_i && cls_i == STORE_CLS[i])
            store_q[i] <= wdata_i;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         status_q <= FO_MASK;
      else if (we_i && cls_i == CL_STATUS)
         status_q <= wdata_i | FO_MASK;
   end

   assign status_o = status_q;
   assign fpcsr_o  = store_q[0];
   assign excpc_o  = store_q[1];
   assign excsr_o  = store_q[2];
   assign maclo_o  = store_q[3];
   assign machi_o  = store_q[4];

   assert_fo_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_q[FO_BIT] == 1'b1);

   assert_npc_nostore_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && cls_i == CL_NEXTPC) |=>
         $stable(status_q) && $stable(store_q[0]) && $stable(store_q[1]) &&
         $stable(store_q[2]) && $stable(store_q[3]) && $stable(store_q[4]));

endmodule

// File: rtl/spr_shadow_bank.sv
module spr_shadow_bank #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 512,
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic              re_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] rd_q;

   always_ff @(posedge clk_i) begin
      if (we_i)
         mem[idx_i] <= wdata_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         rd_q <= '0;
      else if (re_i)
         rd_q <= mem[idx_i];
      else
         rd_q <= '0;
   end

   assign rdata_o = rd_q;

   assert_no_rw_clash_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && re_i));

endmodule

// File: rtl/spr_access_unit.sv
module spr_access_unit
   import spr_unit_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned NUM_REGS     = 'h800,
   parameter int unsigned SHADOW_BASE  = 'h400,
   parameter int unsigned SHADOW_DEPTH = 512,
   parameter int unsigned FO_BIT       = 15,
   parameter logic [DATA_W-1:0] VERSION_VAL = DATA_W'(32'h0001_0203),
   parameter logic [DATA_W-1:0] UNITS_VAL   = DATA_W'(32'h0000_0C05),
   parameter logic [DATA_W-1:0] CPUCFG_VAL  = DATA_W'(32'h0000_0020)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              sup_i,
   input  logic              uacc_i,
   input  logic [DATA_W-1:0] prev_pc_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              redir_o,
   output logic [DATA_W-1:0] redir_pc_o,
   output logic              warn_o,
   output logic [1:0]        warn_code_o,
   output logic [DATA_W-1:0] exc_sr_o
);

   localparam int unsigned SH_IDX_W = (SHADOW_DEPTH > 1) ? $clog2(SHADOW_DEPTH) : 1;

   // elaboration-time parameter checks
   if (NUM_REGS > (1 << ADDR_W)) begin : g_chk_count
      $error("register count does not fit the address width");
   end
   if (SHADOW_DEPTH > 0 && (SHADOW_BASE <= ADR_TOP_FIXED ||
                            SHADOW_BASE + SHADOW_DEPTH > NUM_REGS)) begin : g_chk_window
      $error("shadow window overlaps fixed registers or exceeds register count");
   end
   if (FO_BIT >= DATA_W) begin : g_chk_fo
      $error("fixed-one bit outside data word");
   end

   spr_class_e        cls;
   logic              in_range, rd_legal, wr_legal;
   warn_code_e        code_d;
   logic              accept, we_named, sh_we, sh_re;
   logic [SH_IDX_W-1:0] sh_idx;
   logic [DATA_W-1:0] sh_rdata;
   logic [DATA_W-1:0] status_v, fpcsr_v, excpc_v, excsr_v, maclo_v, machi_v;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rd_named_q;
   logic              sh_sel_q;

   spr_decode #(
      .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
      .SHADOW_BASE(SHADOW_BASE), .SHADOW_DEPTH(SHADOW_DEPTH)
   ) u_decode (
      .addr_i(addr_i), .cls_o(cls), .in_range_o(in_range),
      .rd_legal_o(rd_legal), .wr_legal_o(wr_legal)
   );

   // fault priority: privilege, then range, then per-direction legality, then value
   always_comb begin
      code_d = WARN_NONE;
      if (!(sup_i || uacc_i))
         code_d = WARN_PRIV;
      else if (!in_range)
         code_d = WARN_ADDR;
      else if (wr_i ? !wr_legal : !rd_legal)
         code_d = WARN_ADDR;
      else if (wr_i && cls == CL_TMODE && wdata_i != '0)
         code_d = WARN_VALUE;
   end

   assign accept   = req_i && (code_d == WARN_NONE);
   assign we_named = accept && wr_i;
   assign sh_we    = we_named && (cls == CL_SHADOW);
   assign sh_re    = accept && !wr_i && (cls == CL_SHADOW);
   assign sh_idx   = SH_IDX_W'(addr_i - ADDR_W'(SHADOW_BASE));

   spr_named_regs #(.DATA_W(DATA_W), .FO_BIT(FO_BIT)) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_named), .cls_i(cls),
      .wdata_i(wdata_i), .status_o(status_v), .fpcsr_o(fpcsr_v),
      .excpc_o(excpc_v), .excsr_o(excsr_v), .maclo_o(maclo_v), .machi_o(machi_v)
   );

   if (SHADOW_DEPTH > 0) begin : g_shadow
      spr_shadow_bank #(.DATA_W(DATA_W), .DEPTH(SHADOW_DEPTH)) u_bank (
         .clk_i(clk_i), .rst_ni(rst_ni), .we_i(sh_we), .re_i(sh_re),
         .idx_i(sh_idx), .wdata_i(wdata_i), .rdata_o(sh_rdata)
      );
   end else begin : g_no_shadow
      assign sh_rdata = '0;
   end

   always_comb begin
      case (cls)
         CL_VERSION: rd_mux = VERSION_VAL;
         CL_UNITS:   rd_mux = UNITS_VAL;
         CL_CPUCFG:  rd_mux = CPUCFG_VAL;
         CL_STATUS:  rd_mux = status_v;
         CL_PREVPC:  rd_mux = prev_pc_i;
         CL_FPCSR:   rd_mux = fpcsr_v;
         CL_EXCPC:   rd_mux = excpc_v;
         CL_MACLO:   rd_mux = maclo_v;
         CL_MACHI:   rd_mux = machi_v;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rd_named_q  <= '0;
         sh_sel_q    <= 1'b0;
         redir_o     <= 1'b0;
         redir_pc_o  <= '0;
         warn_o      <= 1'b0;
         warn_code_o <= 2'd0;
      end else begin
         rd_named_q  <= (accept && !wr_i && cls != CL_SHADOW) ? rd_mux : '0;
         sh_sel_q    <= sh_re;
         redir_o     <= we_named && (cls == CL_NEXTPC);
         if (we_named && cls == CL_NEXTPC)
            redir_pc_o <= wdata_i;
         warn_o      <= req_i && (code_d != WARN_NONE);
         warn_code_o <= req_i ? code_d : WARN_NONE;
      end
   end

   assign rd_data_o = sh_sel_q ? sh_rdata : rd_named_q;
   assign exc_sr_o  = excsr_v;

   // assertions
   assert_priv_reject_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(req_i && !sup_i && !uacc_i)) |->
         (warn_code_o == WARN_PRIV && rd_data_o == '0 && !redir_o));

   assert_out_of_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(req_i && (sup_i || uacc_i) &&
                              ({1'b0, addr_i} >= (ADDR_W+1)'(NUM_REGS)))) |->
         (warn_code_o == WARN_ADDR && rd_data_o == '0));

   assert_redir_target_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      redir_o |-> (redir_pc_o == $past(wdata_i) && $past(req_i && wr_i)));

   assert_tmode_value_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(req_i && wr_i && (sup_i || uacc_i) &&
                              addr_i == ADDR_W'(ADR_TMODE) && wdata_i != '0)) |->
         (warn_code_o == WARN_VALUE && !redir_o));

   assert_warn_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      warn_o |-> ($past(req_i) && warn_code_o != 2'd0 && !redir_o));

   assert_warn_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warn_code_o != 2'd0) |-> warn_o);

endmodule

// File: tb/tb_spr_access_unit.sv
module tb_spr_access_unit;

   typedef struct packed {
      logic [7:0]  req;
      logic        wr;
      logic        sup;
      logic        uac;
      logic [15:0] addr;
      logic [31:0] wd;
      logic [31:0] erd;
      logic [1:0]  ecode;
      logic        eredir;
   } vec_t;

   localparam int NV = 40;
   localparam logic [31:0] PREV_PC = 32'hCAFE_0000;

   localparam vec_t VECS [NV] = '{
      '{8'd3, 1'b0,1'b1,1'b0,16'h000,32'h0,32'h00010203,2'd0,1'b0}, // R3
      '{8'd3, 1'b0,1'b1,1'b0,16'h001,32'h0,32'h00000C05,2'd0,1'b0}, // R3
      '{8'd3, 1'b0,1'b1,1'b0,16'h002,32'h0,32'h00000020,2'd0,1'b0}, // R3
      '{8'd11,1'b0,1'b1,1'b0,16'h011,32'h0,32'h00008000,2'd0,1'b0}, // R11
      '{8'd11,1'b0,1'b1,1'b0,16'h014,32'h0,32'h00000000,2'd0,1'b0}, // R11
      '{8'd3, 1'b0,1'b1,1'b0,16'h012,32'h0,32'hCAFE0000,2'd0,1'b0}, // R3
      '{8'd4, 1'b1,1'b1,1'b0,16'h014,32'h00000ABC,32'h0,2'd0,1'b0}, // R4
      '{8'd4, 1'b0,1'b1,1'b0,16'h014,32'h0,32'h00000ABC,2'd0,1'b0}, // R4
      '{8'd4, 1'b1,1'b1,1'b0,16'h020,32'h12345678,32'h0,2'd0,1'b0}, // R4
      '{8'd4, 1'b0,1'b1,1'b0,16'h020,32'h0,32'h12345678,2'd0,1'b0}, // R4
      '{8'd4, 1'b1,1'b1,1'b0,16'h080,32'hDEADBEEF,32'h0,2'd0,1'b0}, // R4
      '{8'd4, 1'b0,1'b1,1'b0,16'h080,32'h0,32'hDEADBEEF,2'd0,1'b0}, // R4
      '{8'd4, 1'b1,1'b1,1'b0,16'h081,32'h0BADF00D,32'h0,2'd0,1'b0}, // R4
      '{8'd4, 1'b0,1'b0,1'b1,16'h081,32'h0,32'h0BADF00D,2'd0,1'b0}, // R4 user access
      '{8'd4, 1'b1,1'b1,1'b0,16'h040,32'h000000A5,32'h0,2'd0,1'b0}, // R4
      '{8'd5, 1'b1,1'b0,1'b1,16'h011,32'h00000003,32'h0,2'd0,1'b0}, // R5
      '{8'd5, 1'b0,1'b1,1'b0,16'h011,32'h0,32'h00008003,2'd0,1'b0}, // R5
      '{8'd5, 1'b1,1'b1,1'b0,16'h011,32'h80008001,32'h0,2'd0,1'b0}, // R5
      '{8'd5, 1'b0,1'b1,1'b0,16'h011,32'h0,32'h80008001,2'd0,1'b0}, // R5
      '{8'd1, 1'b1,1'b0,1'b0,16'h014,32'h0000FFFF,32'h0,2'd1,1'b0}, // R1
      '{8'd1, 1'b0,1'b0,1'b0,16'h014,32'h0,32'h0,2'd1,1'b0},        // R1
      '{8'd1, 1'b0,1'b1,1'b0,16'h014,32'h0,32'h00000ABC,2'd0,1'b0}, // R1 unchanged
      '{8'd6, 1'b1,1'b1,1'b0,16'h010,32'h00004000,32'h0,2'd0,1'b1}, // R6
      '{8'd6, 1'b0,1'b1,1'b0,16'h010,32'h0,32'h0,2'd2,1'b0},        // R6
      '{8'd7, 1'b1,1'b1,1'b0,16'h0A0,32'h0,32'h0,2'd0,1'b0},        // R7
      '{8'd7, 1'b1,1'b1,1'b0,16'h0A0,32'h5,32'h0,2'd3,1'b0},        // R7
      '{8'd7, 1'b0,1'b1,1'b0,16'h0A0,32'h0,32'h0,2'd2,1'b0},        // R7
      '{8'd8, 1'b1,1'b1,1'b0,16'h400,32'h11111111,32'h0,2'd0,1'b0}, // R8
      '{8'd8, 1'b1,1'b1,1'b0,16'h5FF,32'h22222222,32'h0,2'd0,1'b0}, // R8
      '{8'd8, 1'b0,1'b1,1'b0,16'h400,32'h0,32'h11111111,2'd0,1'b0}, // R8
      '{8'd8, 1'b0,1'b1,1'b0,16'h5FF,32'h0,32'h22222222,2'd0,1'b0}, // R8
      '{8'd9, 1'b0,1'b1,1'b0,16'h600,32'h0,32'h0,2'd2,1'b0},        // R9
      '{8'd9, 1'b1,1'b1,1'b0,16'h003,32'h5,32'h0,2'd2,1'b0},        // R9
      '{8'd9, 1'b0,1'b1,1'b0,16'h040,32'h0,32'h0,2'd2,1'b0},        // R9
      '{8'd2, 1'b1,1'b1,1'b0,16'h800,32'h7,32'h0,2'd2,1'b0},        // R2
      '{8'd2, 1'b0,1'b1,1'b0,16'hFFFF,32'h0,32'h0,2'd2,1'b0},       // R2
      '{8'd1, 1'b1,1'b0,1'b0,16'h400,32'h9999,32'h0,2'd1,1'b0},     // R1
      '{8'd8, 1'b0,1'b1,1'b0,16'h400,32'h0,32'h11111111,2'd0,1'b0}, // R8 unchanged
      '{8'd1, 1'b1,1'b0,1'b0,16'h010,32'h8000,32'h0,2'd1,1'b0},     // R1 no redirect
      '{8'd1, 1'b0,1'b0,1'b0,16'hFFFF,32'h0,32'h0,2'd1,1'b0}        // R1 priority
   };

   logic        clk = 1'b0;
   logic        rst_ni = 1'b0;
   logic        req = 1'b0, wr = 1'b0, sup = 1'b0, uac = 1'b0;
   logic [15:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rd_data, redir_pc, exc_sr;
   logic        redir, warn;
   logic [1:0]  warn_code;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   spr_access_unit dut (
      .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .wr_i(wr), .addr_i(addr),
      .wdata_i(wdata), .sup_i(sup), .uacc_i(uac), .prev_pc_i(PREV_PC),
      .rd_data_o(rd_data), .redir_o(redir), .redir_pc_o(redir_pc),
      .warn_o(warn), .warn_code_o(warn_code), .exc_sr_o(exc_sr)
   );

   task automatic check(input string tag, input logic [69:0] act, input logic [69:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // outputs packed as {rd, redir, warn, code, redir_pc}
   function automatic logic [69:0] outs();
      return {rd_data, redir, warn, warn_code, redir_pc[31:0]} & {32'hFFFFFFFF, 3'b111, 2'b11, 32'h0, 1'b0};
   endfunction

   task automatic access(input logic w, input logic s, input logic u,
                         input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      req = 1'b1; wr = w; sup = s; uac = u; addr = a; wdata = d;
      @(negedge clk);
      req = 1'b0; wr = 1'b0; sup = 1'b0; uac = 1'b0; addr = '0; wdata = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_ni = 1'b0;
      repeat (3) @(negedge clk);
      rst_ni = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      do_reset();
      @(negedge clk);
      // R11: outputs idle after reset
      check("R11 reset outputs", {rd_data, redir, warn, warn_code, 32'h0, 1'b0},
            {32'h0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0});
      check("R11 reset exc_sr", {38'h0, exc_sr}, {38'h0, 32'h0});

      for (int i = 0; i < NV; i++) begin
         access(VECS[i].wr, VECS[i].sup, VECS[i].uac, VECS[i].addr, VECS[i].wd);
         checks++;
         if (rd_data !== VECS[i].erd || warn_code !== VECS[i].ecode ||
             warn !== (VECS[i].ecode != 2'd0) || redir !== VECS[i].eredir ||
             (VECS[i].eredir && redir_pc !== VECS[i].wd)) begin
            errors++;
            $display("FAIL R%0d vec %0d actual rd=%h code=%0d warn=%b redir=%b pc=%h expected rd=%h code=%0d redir=%b pc=%h",
                     VECS[i].req, i, rd_data, warn_code, warn, redir, redir_pc,
                     VECS[i].erd, VECS[i].ecode, VECS[i].eredir, VECS[i].wd);
         end
         @(negedge clk);
         // R10: nothing persists into the idle cycle
         check("R10 idle after request", {rd_data, redir, warn, warn_code, 32'h0, 1'b0},
               {32'h0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0});
      end

      // R4: exception status visible on its port
      check("R4 exc_sr", {38'h0, exc_sr}, {38'h0, 32'h000000A5});
      // R6: redirect target held, no further pulse
      check("R6 redirect target held", {38'h0, redir_pc}, {38'h0, 32'h00004000});

      // R10: back-to-back requests each reported in their own cycle
      @(negedge clk);
      req = 1'b1; wr = 1'b0; sup = 1'b1; addr = 16'h000;
      @(negedge clk);
      addr = 16'hFFFF;
      check("R10 back-to-back first", {rd_data, redir, warn, warn_code, 33'h0},
            {32'h00010203, 1'b0, 1'b0, 2'd0, 33'h0});
      @(negedge clk);
      req = 1'b0; sup = 1'b0; addr = '0;
      check("R10 back-to-back second", {rd_data, redir, warn, warn_code, 33'h0},
            {32'h0, 1'b0, 1'b1, 2'd2, 33'h0});

      // R11: reset restores status and clears stored registers
      do_reset();
      @(negedge clk);
      check("R11 exc_sr after reset", {38'h0, exc_sr}, {38'h0, 32'h0});
      access(1'b0, 1'b1, 1'b0, 16'h011, 32'h0);
      check("R11 status after reset", {38'h0, rd_data}, {38'h0, 32'h00008000});
      access(1'b0, 1'b1, 1'b0, 16'h014, 32'h0);
      check("R11 fpcsr after reset", {38'h0, rd_data}, {38'h0, 32'h0});
      access(1'b0, 1'b1, 1'b0, 16'h081, 32'h0);
      check("R11 machi after reset", {38'h0, rd_data}, {38'h0, 32'h0});
      // R5: write with forced bit already clear in data
      access(1'b1, 1'b1, 1'b0, 16'h011, 32'h00000000);
      access(1'b0, 1'b1, 1'b0, 16'h011, 32'h0);
      check("R5 status zero write", {38'h0, rd_data}, {38'h0, 32'h00008000});
      // R6: second redirect with a new target
      access(1'b1, 1'b0, 1'b1, 16'h010, 32'hFFFF_FFFC);
      check("R6 redirect user access", {31'h0, redir, 6'h0, redir_pc},
            {31'h0, 1'b1, 6'h0, 32'hFFFF_FFFC});

      finish_run();
   end

endmodule